// File: doc/BRIEF.md
# Interrupt Mask and Status Bank

This block collects single-cycle event pulses from a serial port into a sticky status register and gates that register with a per-bit mask to drive one level interrupt line. Software never writes the mask directly. It sets mask bits by writing ones to an arm alias and clears them by writing ones to a disarm alias. Zero bits in either write leave the mask as it was, so independent handlers can change their own bits without a read-modify-write.

Software reads the mask and the sticky status at their own addresses, and it acknowledges events by writing ones to the status address. A separate live-condition view returns the current FIFO condition inputs as they are, whatever the mask holds, so a poller can see them while their interrupts are off. Thirteen bit positions are implemented. The low nine carry fixed meanings: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing, 7 parity, 8 receive timeout. Positions 9 to 12 are spare inputs.

Top module: `irq_mask_bank`

## Requirements
- R1: After a synchronous active-high reset, the mask and the status are zero and irq_out is low.
- R2: A write to address 0x08 sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged, effective from the next clock.
- R3: A write to address 0x0C clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R4: Reads of address 0x08 and address 0x0C return zero.
- R5: Address 0x10 reads the mask. A write to 0x10 or to 0x2C changes neither the mask nor the status.
- R6: An event pulse on evt_pulse[i] sets status bit i on the next clock, and the bit stays set until it is cleared.
- R7: Address 0x14 reads the status. Writing ones to 0x14 clears the matching status bits, and zero bits leave status bits unchanged.
- R8: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R9: Only bits 12:0 are implemented. Bits 31:13 of every read are zero, and bits 31:13 of write data have no effect.
- R10: irq_out is high exactly when at least one bit is set in both the status and the mask.
- R11: A read of address 0x2C returns live_cond zero-extended, whatever the mask or status holds.
- R12: rdata is zero when rd_en is low and when the read address is not one of the five mapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is combinational |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| evt_pulse | input | 13 | Event pulses, one per status bit |
| live_cond | input | 13 | Live FIFO condition levels |
| irq_out | output | 1 | Interrupt request |

## Verification
Arm and disarm writes use patterns that overlap bits already set, so a mask that is overwritten instead of being OR-ed or AND-ed shows up at once. Events arrive on masked bits, on unmasked bits, and in the same cycle as a clearing write on the same bit. These cases separate masking errors from latching errors and show which side wins a collision. All-ones writes, writes to the read-only addresses and reads of unmapped addresses confirm that the upper bits, the read-only registers and the decode stay quiet. A behavioural reference compares the interrupt line and the read data on every clock.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    parameter int IRQ_ADDR_W = 8;
    parameter int IRQ_DATA_W = 32;

    localparam logic [IRQ_ADDR_W-1:0] ADR_ARM    = 8'h08;
    localparam logic [IRQ_ADDR_W-1:0] ADR_DISARM = 8'h0C;
    localparam logic [IRQ_ADDR_W-1:0] ADR_MASK   = 8'h10;
    localparam logic [IRQ_ADDR_W-1:0] ADR_STAT   = 8'h14;
    localparam logic [IRQ_ADDR_W-1:0] ADR_LIVE   = 8'h2C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ARM,
        SEL_DISARM,
        SEL_MASK,
        SEL_STAT,
        SEL_LIVE
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [IRQ_ADDR_W-1:0] a);
        case (a)
            ADR_ARM:    return SEL_ARM;
            ADR_DISARM: return SEL_DISARM;
            ADR_MASK:   return SEL_MASK;
            ADR_STAT:   return SEL_STAT;
            ADR_LIVE:   return SEL_LIVE;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_bank_pkg::*;
(
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [IRQ_ADDR_W-1:0] addr,
    output logic                  arm_we,
    output logic                  disarm_we,
    output logic                  stat_we,
    output reg_sel_t              rd_sel
);
    reg_sel_t sel;

    always_comb begin
        sel       = decode_addr(addr);
        arm_we    = wr_en && (sel == SEL_ARM);
        disarm_we = wr_en && (sel == SEL_DISARM);
        stat_we   = wr_en && (sel == SEL_STAT);
        rd_sel    = rd_en ? sel : SEL_NONE;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NUM_BITS = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm_we,
    input  logic                disarm_we,
    input  logic [NUM_BITS-1:0] bits,
    output logic [NUM_BITS-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (arm_we) begin
            mask_q <= mask_q | bits;
        end else if (disarm_we) begin
            mask_q <= mask_q & ~bits;
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_BITS = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_we,
    input  logic [NUM_BITS-1:0] bits,
    input  logic [NUM_BITS-1:0] evt,
    output logic [NUM_BITS-1:0] status_q
);
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[i] <= 1'b0;
            end else if (evt[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_we && bits[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_bank_pkg::*;
#(
    parameter int NUM_BITS = 13
) (
    input  reg_sel_t              rd_sel,
    input  logic [NUM_BITS-1:0]   mask_q,
    input  logic [NUM_BITS-1:0]   status_q,
    input  logic [NUM_BITS-1:0]   live_cond,
    output logic [IRQ_DATA_W-1:0] rdata
);
    localparam int PAD_W = IRQ_DATA_W - NUM_BITS;

    always_comb begin
        case (rd_sel)
            SEL_MASK: rdata = {{PAD_W{1'b0}}, mask_q};
            SEL_STAT: rdata = {{PAD_W{1'b0}}, status_q};
            SEL_LIVE: rdata = {{PAD_W{1'b0}}, live_cond};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_BITS = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [IRQ_ADDR_W-1:0] addr,
    input  logic [IRQ_DATA_W-1:0] wdata,
    output logic [IRQ_DATA_W-1:0] rdata,
    input  logic [NUM_BITS-1:0]   evt_pulse,
    input  logic [NUM_BITS-1:0]   live_cond,
    output logic                  irq_out
);
    logic                arm_we, disarm_we, stat_we;
    reg_sel_t            rd_sel;
    logic [NUM_BITS-1:0] wbits;
    logic [NUM_BITS-1:0] mask_q;
    logic [NUM_BITS-1:0] status_q;
    logic                unused_hi;

    assign wbits     = wdata[NUM_BITS-1:0];
    assign unused_hi = ^wdata[IRQ_DATA_W-1:NUM_BITS];

    irq_reg_decode u_dec (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .arm_we    (arm_we),
        .disarm_we (disarm_we),
        .stat_we   (stat_we),
        .rd_sel    (rd_sel)
    );

    irq_mask_reg #(.NUM_BITS(NUM_BITS)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .arm_we    (arm_we),
        .disarm_we (disarm_we),
        .bits      (wbits),
        .mask_q    (mask_q)
    );

    irq_status_reg #(.NUM_BITS(NUM_BITS)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_we   (stat_we),
        .bits     (wbits),
        .evt      (evt_pulse),
        .status_q (status_q)
    );

    irq_read_mux #(.NUM_BITS(NUM_BITS)) u_rd (
        .rd_sel    (rd_sel),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .live_cond (live_cond),
        .rdata     (rdata)
    );

    assign irq_out = |(status_q & mask_q);
endmodule

// File: rtl/irq_mask_bank_chk.sv
module irq_mask_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int NUM_BITS = 13
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [IRQ_ADDR_W-1:0] addr,
    input logic [IRQ_DATA_W-1:0] wdata,
    input logic [IRQ_DATA_W-1:0] rdata,
    input logic [NUM_BITS-1:0]   evt_pulse,
    input logic [NUM_BITS-1:0]   mask_q,
    input logic [NUM_BITS-1:0]   status_q,
    input logic                  irq_out
);
    AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_ARM) |=>
        ((mask_q & $past(wdata[NUM_BITS-1:0])) == $past(wdata[NUM_BITS-1:0]))); // R2

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_DISARM) |=>
        ((mask_q & $past(wdata[NUM_BITS-1:0])) == '0)); // R3

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == ADR_ARM || addr == ADR_DISARM)) |-> (rdata == '0)); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == ADR_ARM || addr == ADR_DISARM)) |=> $stable(mask_q)); // R5

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse))); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((status_q & mask_q) == '0) |-> !irq_out); // R10

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[IRQ_DATA_W-1:NUM_BITS] == '0); // R9
endmodule

bind irq_mask_bank irq_mask_bank_chk #(.NUM_BITS(NUM_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .evt_pulse (evt_pulse),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .irq_out   (irq_out)
);

// File: tb/irq_mask_bank_bench.sv
module irq_mask_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [12:0] evt_pulse = '0;
    logic [12:0] live_cond = '0;
    logic        irq_out;

    logic [12:0] ref_mask = '0;
    logic [12:0] ref_stat = '0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_mask_bank u_irq_mask_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse),
        .live_cond(live_cond), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_read(input logic r, input logic [7:0] a);
        if (!r) return 32'h0;
        case (a)
            8'h10:   return {19'h0, ref_mask};
            8'h14:   return {19'h0, ref_stat};
            8'h2C:   return {19'h0, live_cond};
            default: return 32'h0;
        endcase
    endfunction

    // irq line against the reference, every cycle (R10)
    always @(negedge clk) begin
        if (!rst && !done) chk("R10 irq", {31'h0, irq_out}, {31'h0, |(ref_stat & ref_mask)});
    end

    task automatic step(input logic w, input logic r, input logic [7:0] a,
                        input logic [31:0] d, input logic [12:0] e, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; evt_pulse = e;
        #1;
        chk(tag, rdata, ref_read(r, a));
        @(posedge clk);
        if (w && a == 8'h08) ref_mask = ref_mask | d[12:0];
        if (w && a == 8'h0C) ref_mask = ref_mask & ~d[12:0];
        if (w && a == 8'h14) ref_stat = ref_stat & ~d[12:0];
        ref_stat = ref_stat | e;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(0, 1, 8'h10, 0, 0, "R1 mask after reset");
        step(0, 1, 8'h14, 0, 0, "R1 status after reset");
        chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        step(1, 0, 8'h08, 32'h105, 0, "R2 arm write");
        step(0, 1, 8'h10, 0, 0, "R2 mask readback");
        chk("R2 mask value", rdata, 32'h105);
        step(1, 0, 8'h08, 32'h002, 0, "R2 arm keeps others");
        step(0, 1, 8'h10, 0, 0, "R2 mask merged");
        chk("R2 merged value", rdata, 32'h107);
        step(0, 1, 8'h08, 0, 0, "R4 arm reads zero");
        step(0, 1, 8'h0C, 0, 0, "R4 disarm reads zero");
        step(1, 0, 8'h0C, 32'h101, 0, "R3 disarm write");
        step(0, 1, 8'h10, 0, 0, "R3 mask after disarm");
        chk("R3 mask value", rdata, 32'h006);
        step(1, 0, 8'h10, 32'h1FFF, 0, "R5 write mask addr");
        step(1, 0, 8'h2C, 32'h1FFF, 0, "R5 write live addr");
        step(0, 1, 8'h10, 0, 0, "R5 mask unchanged");
        chk("R5 mask value", rdata, 32'h006);
        step(0, 0, 8'h00, 0, 13'h021, "R6 events");
        step(0, 1, 8'h14, 0, 0, "R6 status latched");
        chk("R6 status value", rdata, 32'h021);
        chk("R10 masked events", {31'h0, irq_out}, 32'h0);
        step(0, 1, 8'h14, 0, 0, "R6 status held");
        step(1, 0, 8'h08, 32'h020, 0, "R10 arm overrun");
        #2 chk("R10 irq raised", {31'h0, irq_out}, 32'h1);
        step(1, 0, 8'h14, 32'h020, 0, "R7 clear overrun");
        step(0, 1, 8'h14, 0, 0, "R7 status after clear");
        chk("R7 status value", rdata, 32'h001);
        chk("R7 irq dropped", {31'h0, irq_out}, 32'h0);
        step(1, 0, 8'h14, 32'h008, 13'h008, "R8 collision");
        step(0, 1, 8'h14, 0, 0, "R8 status after collision");
        chk("R8 bit kept", rdata, 32'h009);
        step(1, 0, 8'h08, 32'hFFFF_FFFF, 0, "R9 arm all ones");
        step(0, 1, 8'h10, 0, 0, "R9 mask upper zero");
        chk("R9 mask value", rdata, 32'h1FFF);
        step(1, 0, 8'h14, 32'hFFFF_E000, 0, "R9 upper clear bits");
        step(0, 1, 8'h14, 0, 0, "R9 status untouched");
        chk("R9 status value", rdata, 32'h009);
        step(1, 0, 8'h0C, 32'h1FFF, 0, "R11 disarm all");
        live_cond = 13'h1A5C;
        step(0, 1, 8'h2C, 0, 0, "R11 live read");
        chk("R11 live value", rdata, 32'h1A5C);
        step(0, 1, 8'h04, 0, 0, "R12 unmapped read");
        step(0, 0, 8'h14, 0, 0, "R12 no strobe");
        chk("R12 idle rdata", rdata, 32'h0);
        step(0, 0, 8'h00, 0, 0, "idle");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule